// File: doc/BRIEF.md
# Variable-Rate Variable-Order CIC Interpolator

This block raises the sample rate of a stream of signed envelope samples by a power-of-two factor between 1 and 4096. It is a cascaded integrator-comb interpolator: difference stages run once per input sample, a zero-stuffing step inserts the rate change, and accumulating stages run on every output clock. The number of stages is picked per pulse from one to four. One stage gives a sample-and-hold (rectangular window). Two stages give linear interpolation, three quadratic, and four the cubic-spline (Parzen) shape.

A pulse begins with a one-cycle `start` strobe. The strobe loads the rate exponent and the order code, and it clears every stage of filter state. Input samples then arrive over a valid/ready handshake, one per output period. The block emits one output sample per clock for as long as input keeps up. The DC gain of the stage cascade is the rate raised to one less than the stage count. An arithmetic right shift by the matching number of bits removes that gain, so amplitude is preserved, and the result is saturated to the output width.

Top module: `cic_interp`

## Requirements
- R1: During and straight after reset, `in_ready` and `out_valid` are low and `out_data` is zero.
- R2: Until the first `start`, `in_ready` stays low and `out_valid` stays low, whatever `in_valid` does.
- R3: `start` loads `cfg_log2r` as the exponent L of the rate R = 2^L and loads `cfg_order` as the code for a stage count N = code + 1 (0 hold, 1 linear, 2 quadratic, 3 cubic). It also clears all filter state, so the outputs of a pulse depend only on samples accepted after its `start`. `in_ready` is low in the cycle in which `start` is high.
- R4: Each accepted sample produces exactly R output cycles with `out_valid` high, the first one in the cycle after acceptance. `in_ready` is high only when the block is waiting for the sample of the next period.
- R5: With code 0 (hold), every accepted sample appears on `out_data` unchanged in R consecutive output samples.
- R6: Output sample n equals the zero-stuffed input convolved with N cascaded all-ones boxcars of length R. The sum is shifted arithmetically right by (N-1)·L bits, rounding toward minus infinity, and then saturated to the signed 16-bit range.
- R7: With L = 0, the output equals the accepted input one cycle later for every order.
- R8: For constant input c, every output from index N·R onward equals c exactly. This holds at R = 4096 with four stages.
- R9: If no sample is offered when a period ends, `out_valid` goes low, `out_data` holds its value and the filter state freezes. Output resumes as if there had been no gap.
- R10: A `cfg_log2r` above 12 is treated as 12 (R = 4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Pulse strobe: load settings, clear state |
| cfg_log2r | input | 4 | Rate exponent L, sampled on `start` |
| cfg_order | input | 2 | Order code (stage count minus one), sampled on `start` |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block takes the offered sample this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | `out_data` carries a new output sample |
| out_data | output | 16 | Signed interpolated output sample |

## Verification
The bench builds the block with its default parameters: 16-bit samples, exponents up to 12 and up to four stages, so the 64-bit accumulators appear at full width. Randomised pulses use exponents 0 to 4, which keeps the bench's boxcar-cascade model short while covering every order, full-scale inputs, restarts over stale state and input gaps. Directed pulses reach the largest rate: a cubic pulse with DC input at R = 4096 shows that the 36-bit normalising shift is exact, and a hold pulse with an out-of-range exponent shows the clamp to 4096 by counting outputs.

// File: rtl/cic_pkg.sv
// Shared definitions for the CIC interpolator.
// Assumes the order code is the stage count minus one.
package cic_pkg;

    typedef enum logic [1:0] {
        ORD_HOLD   = 2'd0,
        ORD_LINEAR = 2'd1,
        ORD_QUAD   = 2'd2,
        ORD_CUBIC  = 2'd3
    } cic_order_e;

    // Number of bits the normalising shift removes: (stages-1) * log2(rate).
    function automatic int unsigned norm_shift(input int unsigned order_code,
                                               input int unsigned log2r);
        return order_code * log2r;
    endfunction

endpackage

// File: rtl/cic_comb_chain.sv
// Difference (comb) stages of the interpolator, running at the input rate.
// Stage k is active when k <= order code; inactive stages pass their input through.
// Assumes that state advances only on an accepted input sample and that clear wins.
module cic_comb_chain #(
    parameter int ACC_W     = 64,
    parameter int MAX_ORDER = 4,
    parameter int ORD_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    accept,
    input  logic [ORD_W-1:0]        order,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);

    logic signed [ACC_W-1:0] tap [MAX_ORDER+1];

    assign tap[0] = din;

    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
        logic signed [ACC_W-1:0] prev_q;
        logic signed [ACC_W-1:0] diff;

        assign diff       = tap[k] - prev_q;
        assign tap[k+1]   = (ORD_W'(k) <= order) ? diff : tap[k];

        // Keep the previous input of this stage for the next difference.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                prev_q <= '0;
            end else if (accept) begin
                prev_q <= tap[k];
            end
        end
    end

    assign dout = tap[MAX_ORDER];

endmodule

// File: rtl/cic_integ_chain.sv
// Accumulating (integrator) stages, running at the output rate.
// The output is the freshly summed value of the last active stage (index = order code).
// Assumes the modular arithmetic is wide enough for the full gain R^(N-1).
module cic_integ_chain #(
    parameter int ACC_W     = 64,
    parameter int MAX_ORDER = 4,
    parameter int ORD_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic [ORD_W-1:0]        order,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);

    logic signed [ACC_W-1:0] sum [MAX_ORDER+1];

    assign sum[0] = din;

    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
        logic signed [ACC_W-1:0] acc_q;

        assign sum[k+1] = acc_q + sum[k];

        // Accumulate once per output cycle while the block is stepping.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= sum[k+1];
            end
        end
    end

    // Pick the sum of the last stage in use.
    always_comb begin
        dout = sum[1];
        for (int k = 0; k < MAX_ORDER; k++) begin
            if (ORD_W'(k) == order) dout = sum[k+1];
        end
    end

endmodule

// File: rtl/cic_interp.sv
// Variable-rate, variable-order CIC interpolator (top).
// A start strobe loads the rate exponent (clamped to MAX_LOG2R) and order code and clears
// all state. One sample is taken at the start of each period of 2^L output cycles; the
// block stalls, with output held, when none is offered. The output is normalised by an
// arithmetic shift and saturated to DATA_W bits, and is registered one cycle after its step.
module cic_interp #(
    parameter int DATA_W    = 16,
    parameter int MAX_LOG2R = 12,
    parameter int MAX_ORDER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        cfg_log2r,
    input  logic [1:0]        cfg_order,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import cic_pkg::*;

    localparam int ACC_W = DATA_W + MAX_ORDER * MAX_LOG2R;
    localparam int ORD_W = (MAX_ORDER > 1) ? $clog2(MAX_ORDER) : 1;
    localparam int LR_W  = 4;
    localparam int SH_W  = $clog2((MAX_ORDER - 1) * MAX_LOG2R + 1) + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

    logic                    running_q;
    logic [LR_W-1:0]         log2r_q;
    logic [ORD_W-1:0]        order_q;
    logic [MAX_LOG2R-1:0]    phase_q;
    logic [MAX_LOG2R:0]      rate_full;
    logic [MAX_LOG2R-1:0]    phase_last;
    logic                    accept;
    logic                    step;
    logic [SH_W-1:0]         shift_amt;
    logic signed [ACC_W-1:0] comb_out;
    logic signed [ACC_W-1:0] integ_in;
    logic signed [ACC_W-1:0] integ_out;
    logic signed [ACC_W-1:0] scaled;
    logic [DATA_W-1:0]       sat_val;

    assign rate_full  = {{MAX_LOG2R{1'b0}}, 1'b1} << log2r_q;
    assign phase_last = rate_full[MAX_LOG2R-1:0] - MAX_LOG2R'(1);
    assign in_ready   = running_q && (phase_q == '0) && !start;
    assign accept     = in_valid && in_ready;
    assign step       = running_q && !start && ((phase_q != '0) || in_valid);
    assign shift_amt  = SH_W'(norm_shift(int'(order_q), int'(log2r_q)));

    // Load pulse settings on start and track the output phase within a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            log2r_q   <= '0;
            order_q   <= '0;
            phase_q   <= '0;
        end else if (start) begin
            running_q <= 1'b1;
            log2r_q   <= (cfg_log2r > LR_W'(MAX_LOG2R)) ? LR_W'(MAX_LOG2R) : cfg_log2r;
            order_q   <= ORD_W'(cfg_order);
            phase_q   <= '0;
        end else if (step) begin
            phase_q   <= (phase_q == phase_last) ? '0 : phase_q + MAX_LOG2R'(1);
        end
    end

    cic_comb_chain #(.ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .accept (accept),
        .order  (order_q),
        .din    (ACC_W'($signed(in_data))),
        .dout   (comb_out)
    );

    // Zero-stuff: the comb result enters only in the first cycle of each period.
    assign integ_in = (phase_q == '0) ? comb_out : '0;

    cic_integ_chain #(.ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .step   (step),
        .order  (order_q),
        .din    (integ_in),
        .dout   (integ_out)
    );

    // Remove the cascade gain and clip to the output width.
    always_comb begin
        scaled = integ_out >>> shift_amt;
        if (scaled > SAT_HI)      sat_val = SAT_HI[DATA_W-1:0];
        else if (scaled < SAT_LO) sat_val = SAT_LO[DATA_W-1:0];
        else                      sat_val = scaled[DATA_W-1:0];
    end

    // Register one output sample per step; hold the value while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= step;
            if (step) out_data <= sat_val;
        end
    end

endmodule

// File: rtl/cic_interp_chk.sv
// Protocol checker for cic_interp, attached with bind.
// Keeps its own copy of the clamped rate and counts outputs per accepted sample.
module cic_interp_chk #(
    parameter int DATA_W    = 16,
    parameter int MAX_LOG2R = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        cfg_log2r,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic               started_q;
    logic               had_accept_q;
    logic [MAX_LOG2R:0] rate_q;
    logic [MAX_LOG2R:0] seen_q;
    logic               acc;

    assign acc = in_valid && in_ready;

    // Follow the pulse: remember the rate and count outputs since the last accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q    <= 1'b0;
            had_accept_q <= 1'b0;
            rate_q       <= '0;
            seen_q       <= '0;
        end else if (start) begin
            started_q    <= 1'b1;
            had_accept_q <= 1'b0;
            rate_q       <= (MAX_LOG2R+1)'(1) << ((cfg_log2r > 4'(MAX_LOG2R)) ? 4'(MAX_LOG2R) : cfg_log2r);
            seen_q       <= '0;
        end else if (acc) begin
            had_accept_q <= 1'b1;
            seen_q       <= '0;
        end else begin
            seen_q       <= seen_q + (MAX_LOG2R+1)'(out_valid);
        end
    end

    assert_idle_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (!in_ready && !out_valid));

    assert_accept_then_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    assert_period_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && had_accept_q && !start) |-> ((seen_q + (MAX_LOG2R+1)'(out_valid)) == rate_q));

    assert_ready_blocked_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !in_ready);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !out_valid && $past(started_q)) |-> $stable(out_data));

endmodule

bind cic_interp cic_interp_chk #(.DATA_W(DATA_W), .MAX_LOG2R(MAX_LOG2R)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_log2r (cfg_log2r),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_cic_interp.sv
// Self-checking bench for cic_interp: directed corners plus seeded random pulses,
// compared against a boxcar-cascade reference computed here.
module tb_cic_interp;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cfg_log2r = '0;
    logic [1:0]  cfg_order = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    longint xs [0:15];
    longint h  [0:63];
    int     m_cur, r_cur, lr_cur, n_cur, hlen;
    bit     dc_mode;

    cic_interp dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_log2r(cfg_log2r),
        .cfg_order(cfg_order), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an overlong run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // N-fold cascade of all-ones boxcars of length R.
    function automatic void build_h();
        longint tmp [0:63];
        int len = 1;
        for (int i = 0; i < 64; i++) h[i] = 0;
        h[0] = 1;
        for (int s = 0; s < n_cur; s++) begin
            for (int i = 0; i < 64; i++) tmp[i] = 0;
            for (int i = 0; i < len; i++)
                for (int j = 0; j < r_cur; j++)
                    if (i + j < 64) tmp[i+j] += h[i];
            len = len + r_cur - 1;
            for (int i = 0; i < 64; i++) h[i] = tmp[i];
        end
        hlen = len;
    endfunction

    function automatic longint exp_at(input int n);
        longint acc = 0;
        if (n_cur == 1) return xs[n >> lr_cur];
        if (dc_mode) return xs[0];
        for (int j = 0; j < m_cur; j++) begin
            int d = n - j * r_cur;
            if (d >= 0 && d < hlen) acc += xs[j] * h[d];
        end
        return sat16(acc >>> ((n_cur - 1) * lr_cur));
    endfunction

    function automatic bit has_exp(input int n);
        return !dc_mode || n >= n_cur * r_cur;
    endfunction

    // Run one pulse: start, feed m_cur samples with optional gaps, check every output.
    task automatic run_pulse(input int ord, input int lr_cfg, input int stall_pct, input string tag);
        int total;
        n_cur  = ord + 1;
        lr_cur = (lr_cfg > 12) ? 12 : lr_cfg;
        r_cur  = 1 << lr_cur;
        total  = m_cur * r_cur;
        if (!dc_mode && n_cur > 1) build_h();
        @(negedge clk);
        start = 1'b1; cfg_log2r = 4'(lr_cfg); cfg_order = 2'(ord);
        #(CLK_PERIOD/4);
        chk(in_ready == 1'b0, "R3 ready low during start", longint'(in_ready), 0);
        @(negedge clk);
        start = 1'b0;
        fork
            begin : drive
                for (int i = 0; i < m_cur; i++) begin
                    bit taken = 1'b0;
                    while (!taken) begin
                        in_valid = ($urandom % 100) >= stall_pct;
                        in_data  = 16'(xs[i]);
                        #(CLK_PERIOD/4);
                        taken = in_valid && in_ready;
                        @(negedge clk);
                    end
                    in_valid = 1'b0;
                    // R7/R5: first output of the period appears one cycle after acceptance.
                    if (has_exp(i * r_cur))
                        chk(out_valid && (longint'($signed(out_data)) == exp_at(i * r_cur)),
                            {tag, " R7 latency"}, longint'($signed(out_data)), exp_at(i * r_cur));
                end
            end
            begin : watch
                int n = 0;
                bit any = 1'b0;
                logic [15:0] last = '0;
                while (n < total) begin
                    @(negedge clk);
                    if (out_valid) begin
                        if (has_exp(n))
                            chk(longint'($signed(out_data)) == exp_at(n), {tag, " R6 sample"},
                                longint'($signed(out_data)), exp_at(n));
                        last = out_data;
                        any  = 1'b1;
                        n++;
                    end else if (any) begin
                        chk(out_data == last, {tag, " R9 held"}, longint'(out_data), longint'(last));
                    end
                end
                repeat (3) begin
                    @(negedge clk);
                    chk(!out_valid, {tag, " R4 count"}, longint'(out_valid), 0);
                    chk(out_data == last, {tag, " R9 held at end"}, longint'(out_data), longint'(last));
                end
            end
        join
    endtask

    initial begin
        void'($urandom(32'd20240611));
        dc_mode = 1'b0;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!in_ready && !out_valid && out_data == 0, "R1 reset", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!in_ready && !out_valid && out_data == 0, "R1 after reset", longint'(out_data), 0);

        // R2: samples offered before any start are refused.
        in_valid = 1'b1; in_data = 16'h1234;
        repeat (5) begin
            @(negedge clk);
            chk(!in_ready && !out_valid, "R2 idle", longint'(in_ready), 0);
        end
        in_valid = 1'b0;

        // R5: hold at rate 8 with full-scale samples.
        m_cur = 4; xs[0] = 32767; xs[1] = -32768; xs[2] = 5; xs[3] = -1;
        run_pulse(0, 3, 0, "hold");

        // R7: rate 1, cubic, output mirrors input.
        m_cur = 8;
        for (int i = 0; i < 8; i++) xs[i] = (i % 2) ? -32768 : 32767 - i;
        run_pulse(3, 0, 20, "r1 cubic");

        // R6: linear and quadratic at full scale with gaps.
        m_cur = 6;
        for (int i = 0; i < 6; i++) xs[i] = (i % 2) ? -32768 : 32767;
        run_pulse(1, 2, 30, "linear");
        run_pulse(2, 4, 30, "quadratic");

        // R8: DC at the largest rate with four stages.
        dc_mode = 1'b1; m_cur = 5;
        for (int i = 0; i < 5; i++) xs[i] = -12345;
        run_pulse(3, 12, 0, "dc cubic 4096");
        dc_mode = 1'b0;

        // R10: exponent 15 clamps to 4096; hold lets every sample be checked.
        m_cur = 2; xs[0] = 777; xs[1] = -778;
        run_pulse(0, 15, 0, "clamp");

        // R3 and R6: random pulses, each restarting over stale state.
        for (int p = 0; p < 24; p++) begin
            m_cur = 3 + int'($urandom % 12);
            for (int i = 0; i < m_cur; i++) xs[i] = longint'($signed(16'($urandom)));
            run_pulse(int'($urandom % 4), int'($urandom % 5), (p % 2) ? 25 : 0, "random R3");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule